// File: doc/BRIEF.md
# Bidirectional Counter with Wrap or Clamp Limits

This block holds a three-bit count in the range 0 to 7 and advances it by one on every rising clock edge. A direction input chooses whether the step goes up or down. A limit-mode input chooses what happens when the step would leave the range: in wrap mode the count rolls over to the opposite end, and in clamp mode it holds at the end it reached.

Both control inputs are sampled on the same edge that updates the count, and they may change on any cycle. The next value always comes from the current count under the control settings seen at that edge, so the count moves from one sequence to another with no extra state and no lost cycle. A synchronous active-low reset loads zero.

Top module: `updown_limit_counter`

## Requirements
- R1: While rst_n is 0 at a rising edge, the count becomes 0 at that edge.
- R2: With dir_down=0 and count below 7, each rising edge adds one to the count.
- R3: With dir_down=1 and count above 0, each rising edge subtracts one from the count.
- R4: With clamp=0 and dir_down=0, a count of 7 becomes 0 at the next edge.
- R5: With clamp=0 and dir_down=1, a count of 0 becomes 7 at the next edge.
- R6: With clamp=1 and dir_down=0, a count of 7 stays 7 for as long as both settings are kept.
- R7: With clamp=1 and dir_down=1, a count of 0 stays 0 for as long as both settings are kept.
- R8: When dir_down is reversed while the count is held at a limit in clamp mode, the count leaves that limit at the very next edge (7 to 6, or 0 to 1).
- R9: A change of dir_down or clamp takes effect at the same edge that samples it; the step applied at that edge follows the new settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; loads count 0 |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| clamp | input | 1 | 0 wraps at the ends, 1 holds at the ends |
| count | output | 3 | Current count value, 0 to 7 |

## Verification
Every result is due exactly one edge after the inputs that cause it: the count is a single register, and the controls feed it through logic alone with no pipeline stage. The bench changes inputs half a period after a rising edge, so they are settled well before the next edge, and reads the count a quarter period after each edge, when the register has updated and no process is racing it. Each expected value is worked out in the bench from the previous expected value and the settings it just drove, so a sequence switch in the middle of a run is checked on the very edge that applies it.

// File: rtl/updown_limit_counter_pkg.sv
// Package: shared types and widths for the up/down limit counter.
// Assumes: the count width is fixed by the block's function at three bits.
package updown_limit_counter_pkg;
    localparam int CNT_W = 3;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MIN = '0;

    typedef logic [CNT_W-1:0] cnt_t;

    // Direction of travel applied at an edge.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;
endpackage

// File: rtl/updown_step.sv
// Module: updown_step
// Computes the plain neighbour of a count value in the requested direction,
// rolling over at the ends of the range. Also flags when the step would cross
// a limit. Pure combinational; assumes the width comes from the package.
module updown_step
    import updown_limit_counter_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic [W-1:0] cur,
    input  logic         down,
    output logic [W-1:0] stepped,
    output logic         at_edge
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] BOT = {W{1'b0}};

    // Purpose: form the rolled neighbour and detect a limit crossing.
    always_comb begin
        if (down) begin
            stepped = cur - 1'b1;
            at_edge = (cur == BOT);
        end else begin
            stepped = cur + 1'b1;
            at_edge = (cur == TOP);
        end
    end
endmodule

// File: rtl/limit_select.sv
// Module: limit_select
// Chooses the next count: the rolled neighbour, or the current value when
// clamp mode is on and the step would cross a limit. Combinational; assumes
// at_edge is asserted only when the step leaves the range.
module limit_select
    import updown_limit_counter_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] stepped,
    input  logic         at_edge,
    input  logic         clamp,
    output logic [W-1:0] next_val
);
    // Purpose: hold at the limit in clamp mode, otherwise take the step.
    always_comb begin
        if (clamp && at_edge) begin
            next_val = cur;
        end else begin
            next_val = stepped;
        end
    end
endmodule

// File: rtl/updown_limit_counter.sv
// Module: updown_limit_counter
// Three-bit counter that steps up or down every clock and either wraps or
// clamps at the ends of its range. Controls are sampled on the updating edge.
// Assumes: rst_n is synchronous and active low; reset value is zero.
module updown_limit_counter
    import updown_limit_counter_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir_down,
    input  logic       clamp,
    output logic [2:0] count
);
    cnt_t cnt_q;
    cnt_t stepped;
    cnt_t next_val;
    logic at_edge;

    updown_step #(.W(CNT_W)) u_step (
        .cur     (cnt_q),
        .down    (dir_down),
        .stepped (stepped),
        .at_edge (at_edge)
    );

    limit_select #(.W(CNT_W)) u_sel (
        .cur      (cnt_q),
        .stepped  (stepped),
        .at_edge  (at_edge),
        .clamp    (clamp),
        .next_val (next_val)
    );

    // Purpose: count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_MIN;
        end else begin
            cnt_q <= next_val;
        end
    end

    assign count = cnt_q;

    // Tracks whether at least one edge has passed since reset released,
    // so $past refers only to cycles after reset.
    logic past_ok;
    // Purpose: qualify history-based assertions.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (count == CNT_MIN));

    assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_down && count != CNT_MAX) |=> (count == $past(count) + 3'd1));

    assert_down_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_down && count != CNT_MIN) |=> (count == $past(count) - 3'd1));

    assert_wrap_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clamp && !dir_down && count == CNT_MAX) |=> (count == CNT_MIN));

    assert_wrap_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clamp && dir_down && count == CNT_MIN) |=> (count == CNT_MAX));

    assert_hold_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp && !dir_down && count == CNT_MAX) |=> (count == CNT_MAX));

    assert_hold_bot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp && dir_down && count == CNT_MIN) |=> (count == CNT_MIN));

    assert_leave_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && clamp && count == CNT_MAX && $past(count) == CNT_MAX && dir_down)
        |=> (count == 3'd6));

    assert_moves_by_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rst_n) && !$stable(count)) |->
        (count - $past(count) == 3'd1 || $past(count) - count == 3'd1 ||
         (count == CNT_MIN && $past(count) == CNT_MAX) ||
         (count == CNT_MAX && $past(count) == CNT_MIN)));
endmodule

// File: tb/updown_limit_counter_tb.sv
module updown_limit_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_down = 1'b0;
    logic       clamp = 1'b0;
    logic [2:0] count;

    int n_checks = 0;
    int n_fail = 0;
    logic [2:0] model = 3'd0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    updown_limit_counter u_dut (
        .clk(clk), .rst_n(rst_n), .dir_down(dir_down),
        .clamp(clamp), .count(count)
    );

    task automatic check(input string req, input logic [2:0] exp);
        n_checks++;
        if (count !== exp) begin
            n_fail++;
            $display("FAIL %s: count=%0d expected=%0d", req, count, exp);
        end
    endtask

    // Apply settings half a period after an edge, advance one edge,
    // update the model, sample a quarter period after the edge.
    task automatic step(input logic d, input logic c, input string req);
        dir_down = d;
        clamp = c;
        @(posedge clk);
        if (!d) model = (c && model == 3'd7) ? 3'd7 : model + 3'd1;
        else    model = (c && model == 3'd0) ? 3'd0 : model - 3'd1;
        #2;
        check(req, model);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); #2;
        model = 3'd0;
        check("R1", 3'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_up_wrap();
        do_reset();
        for (int i = 0; i < 7; i++) step(1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, "R4");
        step(1'b0, 1'b0, "R2");
    endtask

    task automatic t_down_wrap();
        do_reset();
        step(1'b1, 1'b0, "R5");
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, "R3");
    endtask

    task automatic t_clamp_top();
        do_reset();
        for (int i = 0; i < 7; i++) step(1'b0, 1'b1, "R2");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R6");
        step(1'b1, 1'b1, "R8");
        step(1'b1, 1'b1, "R3");
    endtask

    task automatic t_clamp_bot();
        do_reset();
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R7");
        step(1'b0, 1'b1, "R8");
        step(1'b0, 1'b1, "R2");
    endtask

    task automatic t_switching();
        do_reset();
        step(1'b0, 1'b0, "R9");
        step(1'b0, 1'b0, "R9");
        step(1'b1, 1'b0, "R9");
        step(1'b1, 1'b0, "R9");
        step(1'b1, 1'b1, "R9");
        step(1'b1, 1'b0, "R9");
        step(1'b1, 1'b1, "R9");
        step(1'b0, 1'b1, "R9");
        step(1'b1, 1'b0, "R9");
        step(1'b1, 1'b0, "R9");
        step(1'b0, 1'b0, "R9");
        step(1'b0, 1'b1, "R9");
        // mid-run reset loads zero
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R2");
        do_reset();
    endtask

    initial begin
        @(negedge clk);
        t_up_wrap();
        t_down_wrap();
        t_clamp_top();
        t_clamp_bot();
        t_switching();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule